// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 18-bit words. It sits between a producer on its own write clock and a consumer on its own read clock. The write side stores a word on each write-clock edge where the active-low write enable is asserted. The read side moves the oldest word into a registered output on each read-clock edge where the active-low read enable is asserted. Each word reaches the output only after it has been requested, and this includes the first word written into an empty buffer.

Five active-low status outputs report the fill level: full, empty, almost-full, almost-empty and more-than-half-full. Full, almost-full and half-full are computed and registered on the write clock. Empty and almost-empty are computed and registered on the read clock. Each side sees the other side's pointer through a two-stage synchroniser carrying Gray code, so a flag that depends on the far side's activity can lag by a few cycles. That lag only ever errs on the safe side.

The two thresholds come from a small offset store in the write domain. While the load input is low, each write-enabled edge loads the low 12 data bits into the empty-side offset and then the full-side offset, alternating between them. The depth must be a power of two between 256 and 4096. A single active-high synchronous reset input must be held for at least three edges of each clock.

Top module: `dcfifo_pflag`

## Requirements
- R1: While reset is held, both pointers return to location zero. After reset, full_n, afull_n and hfull_n read 1, and empty_n and aempty_n read 0.
- R2: Reset clears rdata to all zeros. It also returns both offsets to their default: 31 for depth 256, 63 for depth 512, and 127 for larger depths.
- R3: A write request (wen_n=0, ld_n=1) made while full_n is 0 stores nothing, and the stored words and their order are unchanged.
- R4: A read request made while empty_n is 0 leaves rdata unchanged. With ren_n=1, rdata holds its value.
- R5: With no reads, full_n goes to 0 after exactly DEPTH accepted writes and not before. full_n is registered on wclk and empty_n on rclk.
- R6: Words leave in the order they were written. A word written into an empty FIFO appears on rdata only after a read request, on the rclk edge that accepts that request.
- R7: Once settled, afull_n is 0 exactly when the stored count is at least DEPTH minus the full-side offset.
- R8: Once settled, aempty_n is 0 exactly when the stored count is no greater than the empty-side offset.
- R9: Once settled, hfull_n is 0 exactly when the stored count exceeds DEPTH/2. It returns to 1 once the count falls to DEPTH/2 or below.
- R10: On a wclk edge with ld_n=0 and wen_n=0, wdata[11:0] is loaded into one offset, and nothing enters the FIFO. The offset chosen alternates between the empty-side offset and the full-side offset, starting with the empty-side offset after reset, and the alternation carries on across intervals where ld_n is high. An edge with ld_n=0 and wen_n=1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| wen_n | input | 1 | Write enable, active low |
| ld_n | input | 1 | Offset load select, active low |
| wdata | input | 18 | Write data word; bits 11:0 carry offset values during loads |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | 18 | Registered read data |
| full_n | output | 1 | Full, active low, on wclk |
| afull_n | output | 1 | Almost-full, active low, on wclk |
| hfull_n | output | 1 | More-than-half-full, active low, on wclk |
| empty_n | output | 1 | Empty, active low, on rclk |
| aempty_n | output | 1 | Almost-empty, active low, on rclk |

## Verification
The bench builds the block with DEPTH set to 256 and drives both clocks from one 125 MHz source. This keeps the synchroniser lag at a fixed number of edges. With a depth this small, a complete fill to full, an overflow attempt and a complete drain fit in a short run, so every flag boundary is stepped across in both directions. The bench first checks the boundaries at the default offset of 31. It then loads small offsets of 3 and 5, which moves both almost-flag boundaries to counts that are easy to reach, and checks them there.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    localparam int WORD_W  = 18;
    localparam int OFS_W   = 12;
    localparam int PTR_MAX = 13;   // pointer width for the largest depth (4096) plus one wrap bit

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [OFS_W-1:0]   ofs_t;
    typedef logic [PTR_MAX-1:0] ptr_t;

    // flags owned by the write clock, all active low
    typedef struct packed {
        logic full_n;
        logic afull_n;
        logic hfull_n;
    } wflags_t;

    // flags owned by the read clock, all active low
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflags_t;

    function automatic int dflt_offset(input int depth);
        if (depth <= 256)      return 31;
        else if (depth <= 512) return 63;
        else                   return 127;
    endfunction

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pf_offsets.sv
module pf_offsets
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic wclk,
    input  logic rst,
    input  logic ld_n,
    input  logic wen_n,
    input  ofs_t din,
    output ofs_t empty_ofs,
    output ofs_t full_ofs
);
    localparam ofs_t DFLT = OFS_W'(dflt_offset(DEPTH));

    logic sel_full;   // 0: next load goes to the empty-side offset

    always_ff @(posedge wclk) begin
        if (rst) begin
            empty_ofs <= DFLT;
            full_ofs  <= DFLT;
            sel_full  <= 1'b0;
        end else if (!ld_n && !wen_n) begin
            if (sel_full) full_ofs  <= din;
            else          empty_ofs <= din;
            sel_full <= !sel_full;
        end
    end

    p_ofs_default_r2: assert property (@(posedge wclk) disable iff (rst)
        $fell(rst) |-> (empty_ofs == DFLT && full_ofs == DFLT));

    p_ofs_quiet_r10: assert property (@(posedge wclk) disable iff (rst)
        ld_n |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: rtl/pf_wside.sv
module pf_wside
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wen_n,
    input  logic          ld_n,
    input  logic [PW-1:0] rgray_s,
    input  ofs_t          full_ofs,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [PW-1:0] wgray,
    output wflags_t       flags
);
    localparam int CW = ((PW > OFS_W) ? PW : OFS_W) + 1;

    logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx;
    ptr_t          rs_wide, g_nx;

    assign we      = !wen_n && ld_n && flags.full_n;
    assign wbin_nx = wbin + PW'(we);
    assign rs_wide = gray2bin(PTR_MAX'(rgray_s));
    assign rbin_s  = rs_wide[PW-1:0];
    assign used_nx = wbin_nx - rbin_s;
    assign g_nx    = bin2gray(PTR_MAX'(wbin_nx));
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            flags <= '{full_n: 1'b1, afull_n: 1'b1, hfull_n: 1'b1};
        end else begin
            wbin          <= wbin_nx;
            wgray         <= g_nx[PW-1:0];
            flags.full_n  <= (used_nx != PW'(DEPTH));
            flags.afull_n <= !((CW'(used_nx) + CW'(full_ofs)) >= CW'(DEPTH));
            flags.hfull_n <= !(used_nx > PW'(DEPTH / 2));
        end
    end

    p_rst_wflags_r1: assert property (@(posedge wclk) disable iff (rst)
        $fell(rst) |-> (flags.full_n && flags.afull_n && flags.hfull_n));

    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
        (wbin - rbin_s) <= PW'(DEPTH));

    p_full_implies_r7: assert property (@(posedge wclk) disable iff (rst)
        !flags.full_n |-> (!flags.afull_n && !flags.hfull_n));

    p_gray_step_r5: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/pf_rside.sv
module pf_rside
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          ren_n,
    input  logic [PW-1:0] wgray_s,
    input  ofs_t          empty_ofs,
    output logic [AW-1:0] raddr,
    output logic          re,
    output logic [PW-1:0] rgray,
    output rflags_t       flags
);
    localparam int CW = ((PW > OFS_W) ? PW : OFS_W) + 1;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, used_nx;
    ptr_t          ws_wide, g_nx;

    assign re      = !ren_n && flags.empty_n;
    assign rbin_nx = rbin + PW'(re);
    assign ws_wide = gray2bin(PTR_MAX'(wgray_s));
    assign wbin_s  = ws_wide[PW-1:0];
    assign used_nx = wbin_s - rbin_nx;
    assign g_nx    = bin2gray(PTR_MAX'(rbin_nx));
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            flags <= '{empty_n: 1'b0, aempty_n: 1'b0};
        end else begin
            rbin           <= rbin_nx;
            rgray          <= g_nx[PW-1:0];
            flags.empty_n  <= (used_nx != '0);
            flags.aempty_n <= !(CW'(used_nx) <= CW'(empty_ofs));
        end
    end

    p_rst_rflags_r1: assert property (@(posedge rclk) disable iff (rst)
        $fell(rst) |-> (!flags.empty_n && !flags.aempty_n));

    p_empty_implies_r8: assert property (@(posedge rclk) disable iff (rst)
        !flags.empty_n |-> !flags.aempty_n);

    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (rst)
        (wbin_s - rbin) <= PW'(DEPTH));
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        rst,
    input  logic        wen_n,
    input  logic        ld_n,
    input  logic [17:0] wdata,
    input  logic        ren_n,
    output logic [17:0] rdata,
    output logic        full_n,
    output logic        afull_n,
    output logic        hfull_n,
    output logic        empty_n,
    output logic        aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    word_t         mem [DEPTH];
    logic [AW-1:0] waddr, raddr;
    logic          we, re;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    ofs_t          empty_ofs, full_ofs;
    wflags_t       wfl;
    rflags_t       rfl;

    pf_offsets #(.DEPTH(DEPTH)) u_ofs (
        .wclk(wclk), .rst(rst), .ld_n(ld_n), .wen_n(wen_n),
        .din(wdata[OFS_W-1:0]), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    pf_wside #(.DEPTH(DEPTH)) u_wside (
        .wclk(wclk), .rst(rst), .wen_n(wen_n), .ld_n(ld_n), .rgray_s(rgray_s),
        .full_ofs(full_ofs), .waddr(waddr), .we(we), .wgray(wgray), .flags(wfl)
    );

    pf_rside #(.DEPTH(DEPTH)) u_rside (
        .rclk(rclk), .rst(rst), .ren_n(ren_n), .wgray_s(wgray_s),
        .empty_ofs(empty_ofs), .raddr(raddr), .re(re), .rgray(rgray), .flags(rfl)
    );

    pf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    pf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

    assign full_n   = wfl.full_n;
    assign afull_n  = wfl.afull_n;
    assign hfull_n  = wfl.hfull_n;
    assign empty_n  = rfl.empty_n;
    assign aempty_n = rfl.aempty_n;

    p_rst_dout_r2: assert property (@(posedge rclk) disable iff (rst)
        $fell(rst) |-> (rdata == '0));

    p_hold_dout_r4: assert property (@(posedge rclk) disable iff (rst)
        (ren_n || !empty_n) |=> $stable(rdata));
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
    localparam int DEPTH = 256;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wen_n = 1'b1, ld_n = 1'b1, ren_n = 1'b1;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        full_n, afull_n, hfull_n, empty_n, aempty_n;

    int          n_chk = 0, n_bad = 0;
    logic [17:0] mq [$];
    logic [17:0] mdout = '0;
    int          mn = 31, mm = 31;
    bit          psel = 1'b0;

    // op codes: 1 write, 2 read, 0 idle
    localparam logic [19:0] VEC [12] = '{
        {2'd1, 18'h00011}, {2'd1, 18'h22222}, {2'd2, 18'h00000}, {2'd1, 18'h3FFFF},
        {2'd2, 18'h00000}, {2'd2, 18'h00000}, {2'd2, 18'h00000}, {2'd0, 18'h00000},
        {2'd1, 18'h15A5A}, {2'd1, 18'h0A5A5}, {2'd2, 18'h00000}, {2'd2, 18'h00000}
    };

    dcfifo_pflag #(.DEPTH(DEPTH)) u_dut (
        .wclk(clk), .rclk(clk), .rst(rst), .wen_n(wen_n), .ld_n(ld_n), .wdata(wdata),
        .ren_n(ren_n), .rdata(rdata), .full_n(full_n), .afull_n(afull_n),
        .hfull_n(hfull_n), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic push(input logic [17:0] d);
        wen_n = 1'b0; wdata = d;
        @(negedge clk);
        wen_n = 1'b1;
        if (mq.size() < DEPTH) mq.push_back(d);
    endtask

    task automatic pop();
        ren_n = 1'b0;
        @(negedge clk);
        ren_n = 1'b1;
        if (mq.size() > 0) mdout = mq.pop_front();
    endtask

    task automatic prog(input logic [11:0] v);
        ld_n = 1'b0; wen_n = 1'b0; wdata = {6'h00, v};
        @(negedge clk);
        ld_n = 1'b1; wen_n = 1'b1;
        if (psel) mm = int'(v); else mn = int'(v);
        psel = !psel;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        settle(3);
        rst = 1'b0;
        mq.delete(); mdout = '0; mn = 31; mm = 31; psel = 1'b0;
        settle(1);
    endtask

    task automatic check_flags(input string ctx);
        int c;
        c = mq.size();
        chk({"R5 full_n ", ctx},   32'(full_n),   32'(c != DEPTH));
        chk({"R4 empty_n ", ctx},  32'(empty_n),  32'(c != 0));
        chk({"R7 afull_n ", ctx},  32'(afull_n),  32'(!(c >= DEPTH - mm)));
        chk({"R8 aempty_n ", ctx}, 32'(aempty_n), 32'(!(c <= mn)));
        chk({"R9 hfull_n ", ctx},  32'(hfull_n),  32'(!(c > HALF)));
    endtask

    task automatic fill_to(input int target, input string ctx);
        while (mq.size() < target) push(18'(mq.size() * 7 + 18'h100));
        settle(5);
        check_flags(ctx);
    endtask

    task automatic drain_to(input int target, input string ctx);
        while (mq.size() > target) begin
            pop();
            chk({"R6 order ", ctx}, 32'(rdata), 32'(mdout));
        end
        settle(5);
        check_flags(ctx);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1, R2: reset state
        check_flags("R1 after reset");
        chk("R2 rdata cleared", 32'(rdata), 32'h0);

        // table walk: R4, R6 with flags
        foreach (VEC[i]) begin
            case (VEC[i][19:18])
                2'd1:    push(VEC[i][17:0]);
                2'd2:    pop();
                default: settle(1);
            endcase
            settle(5);
            chk("R6 R4 table rdata", 32'(rdata), 32'(mdout));
            check_flags("table");
        end

        // R6: first word into empty FIFO needs a read request
        mdout = rdata;
        push(18'h2C0DE);
        settle(6);
        chk("R6 first word not presented", 32'(rdata), 32'(mdout));
        chk("R6 empty released", 32'(empty_n), 32'h1);
        pop();
        chk("R6 first word after read", 32'(rdata), 32'h2C0DE);

        // R9, R7, R5 boundaries while filling
        fill_to(HALF, "R9 at half");
        fill_to(HALF + 1, "R9 above half");
        fill_to(DEPTH - mm - 1, "R7 below");
        fill_to(DEPTH - mm, "R7 at");
        fill_to(DEPTH - 1, "R5 one short");
        fill_to(DEPTH, "R5 full");

        // R3: write while full is dropped
        push(18'h3ABCD);
        settle(5);
        check_flags("R3 after overflow try");
        drain_to(HALF + 1, "R9 drain above half");
        drain_to(HALF, "R9 drain at half");
        drain_to(mn + 1, "R8 above");
        drain_to(mn, "R8 at");
        drain_to(0, "R3 drained");

        // R4: read while empty ignored
        mdout = rdata;
        pop();
        settle(3);
        chk("R4 empty read ignored", 32'(rdata), 32'(mdout));

        // R10: offset loading sequence
        prog(12'd3);
        settle(1);
        ld_n = 1'b0; wen_n = 1'b1; wdata = 18'h00FFF;
        @(negedge clk);
        ld_n = 1'b1;
        prog(12'd5);
        settle(5);
        chk("R10 load stores no word", 32'(empty_n), 32'h0);
        fill_to(3, "R10 R8 n=3 at");
        fill_to(4, "R10 R8 n=3 above");
        fill_to(DEPTH - 6, "R10 R7 m=5 below");
        fill_to(DEPTH - 5, "R10 R7 m=5 at");

        // R1, R2: reset with data present restores defaults
        do_reset();
        settle(4);
        check_flags("R1 mid reset");
        chk("R2 rdata cleared again", 32'(rdata), 32'h0);
        fill_to(31, "R2 default n at");
        fill_to(32, "R2 default n above");
        fill_to(DEPTH - 32, "R2 default m below");
        fill_to(DEPTH - 31, "R2 default m at");

        summary();
        $finish;
    end
endmodule